// File: doc/BRIEF.md
# Bit-serial FSK square-wave modulator

This block turns bytes from a network layer into a frequency-shift-keyed square wave on a single output pin. Each byte is accepted over a valid/ready handshake and shifted out least significant bit first. The bit currently on the line selects the half period of the square wave. A space ('0') uses one divide factor of the local oscillator clock. A mark ('1') uses a second factor, or a third, longer one when wide deviation is selected.

Each bit lasts a fixed number of oscillator clocks. That bit timer runs on its own and does not follow the tone counter. A change of tone takes effect only when the current half period completes, so the waveform keeps a continuous phase and has no short pulses. The defaults assume a 24 MHz oscillator and give the following results:

- space at about 133.3 kHz (half period of 90 clocks)
- mark at about 131.8 kHz (half period of 91 clocks)
- wide mark at about 130.4 kHz (half period of 92 clocks)
- bit rate of 2400 bit/s (10000 clocks per bit)

The line is half duplex. Output enable and busy are asserted only while bits are going out. When idle, the tone output stays low.

Top module: `fsk_modulator`

## Requirements
- R1: While the current bit is 0, each half period of `tone_o` lasts HALF_SPACE clocks (default 90).
- R2: While the current bit is 1 and `wide_dev_i` is low, each half period lasts HALF_MARK clocks (default 91).
- R3: While the current bit is 1 and `wide_dev_i` is high, each half period lasts HALF_WIDE clocks (default 92). Space bits are unaffected by `wide_dev_i`.
- R4: Data bits go out least significant bit first, and each bit occupies exactly BIT_CLKS clocks, so a byte keeps the block busy for 8*BIT_CLKS clocks.
- R5: A change of half-period length takes effect only at the end of the half period in force. The first half period of a transmission is low and uses the length of the first bit.
- R6: A byte is taken on a clock edge where `valid_i` and `ready_o` are both high. `ready_o` is high only when no bits remain, or during the final clock of the last bit. It is low on the clock after an accepted byte.
- R7: `tx_busy_o` and `tone_en_o` rise on the clock after the first accepted byte. They fall when the last bit period ends. A byte accepted in the final clock of the last bit keeps them high without a gap.
- R8: Whenever `tone_en_o` is low, `tone_o` is low.
- R9: After reset, `ready_o` is high and `tx_busy_o`, `tone_en_o` and `tone_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Local oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Byte to transmit |
| valid_i | input | 1 | `data_i` holds a byte to send |
| ready_o | output | 1 | Shifter can take a byte this cycle |
| wide_dev_i | input | 1 | Selects the longer mark half period |
| tx_busy_o | output | 1 | Transmission in progress |
| tone_o | output | 1 | FSK square wave |
| tone_en_o | output | 1 | Line driver enable for `tone_o` |

## Verification
The half-period property assumes that `wide_dev_i` changes only while the block is idle. A change in the middle of a mark bit would produce one half period of the old length, which is legal, so the property only ever admits the three configured lengths. The handshake properties assume that `valid_i` is driven synchronously and held until it is accepted. The stimulus drives every input on the falling edge and toggles the deviation select only after busy has dropped. It also holds `valid_i` across the ready window, including the last-clock overlap used for back-to-back bytes.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

  typedef enum logic [1:0] {
    TONE_SPACE = 2'd0,
    TONE_MARK  = 2'd1,
    TONE_WIDE  = 2'd2
  } tone_sel_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fsk_bit_shifter.sv
module fsk_bit_shifter #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned BIT_CLKS = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              bit_o
);

  localparam int unsigned CNT_W = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
  localparam int unsigned BL_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CLKS - 1);
  localparam logic [BL_W-1:0]  BL_FULL  = BL_W'(DATA_W);

  logic [DATA_W-1:0] shift_q;
  logic [BL_W-1:0]   bits_left_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              bit_end, last_end, accept;

  assign busy_o   = (bits_left_q != '0);
  assign bit_end  = (bit_cnt_q == CNT_LAST);
  assign last_end = (bits_left_q == BL_W'(1)) && bit_end;
  assign ready_o  = !busy_o || last_end;
  assign accept   = valid_i && ready_o;
  assign bit_o    = shift_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q     <= '0;
      bits_left_q <= '0;
      bit_cnt_q   <= '0;
    end else if (accept) begin
      shift_q     <= data_i;
      bits_left_q <= BL_FULL;
      bit_cnt_q   <= '0;
    end else if (busy_o) begin
      if (bit_end) begin
        bit_cnt_q   <= '0;
        shift_q     <= shift_q >> 1;
        bits_left_q <= bits_left_q - BL_W'(1);
      end else begin
        bit_cnt_q <= bit_cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/fsk_half_sel.sv
module fsk_half_sel
  import fsk_mod_pkg::*;
#(
  parameter int unsigned HALF_W     = 7,
  parameter int unsigned HALF_SPACE = 90,
  parameter int unsigned HALF_MARK  = 91,
  parameter int unsigned HALF_WIDE  = 92
) (
  input  logic              bit_i,
  input  logic              wide_i,
  output logic [HALF_W-1:0] half_o
);

  tone_sel_e sel;

  always_comb begin
    if (!bit_i)      sel = TONE_SPACE;
    else if (wide_i) sel = TONE_WIDE;
    else             sel = TONE_MARK;
  end

  always_comb begin
    unique case (sel)
      TONE_MARK: half_o = HALF_W'(HALF_MARK);
      TONE_WIDE: half_o = HALF_W'(HALF_WIDE);
      default:   half_o = HALF_W'(HALF_SPACE);
    endcase
  end

endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
  parameter int unsigned HALF_W     = 7,
  parameter int unsigned HALF_SPACE = 90,
  parameter int unsigned HALF_MARK  = 91,
  parameter int unsigned HALF_WIDE  = 92
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic bit_i,
  input  logic wide_i,
  output logic tone_o
);

  logic [HALF_W-1:0] half_sel, half_q, half_now, cnt_q;
  logic              run_q, tone_q;

  fsk_half_sel #(
    .HALF_W    (HALF_W),
    .HALF_SPACE(HALF_SPACE),
    .HALF_MARK (HALF_MARK),
    .HALF_WIDE (HALF_WIDE)
  ) u_sel (
    .bit_i (bit_i),
    .wide_i(wide_i),
    .half_o(half_sel)
  );

  // first active cycle takes the length straight from the current bit
  assign half_now = run_q ? half_q : half_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      tone_q <= 1'b0;
      cnt_q  <= '0;
      half_q <= '0;
    end else begin
      run_q <= busy_i;
      if (!busy_i) begin
        tone_q <= 1'b0;
        cnt_q  <= '0;
        half_q <= half_sel;
      end else if (cnt_q == half_now - HALF_W'(1)) begin
        tone_q <= !tone_q;
        cnt_q  <= '0;
        half_q <= half_sel;
      end else begin
        cnt_q  <= cnt_q + HALF_W'(1);
        half_q <= half_now;
      end
    end
  end

  assign tone_o = tone_q;

endmodule

// File: rtl/fsk_modulator.sv
module fsk_modulator
  import fsk_mod_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BIT_CLKS   = 10000,
  parameter int unsigned HALF_SPACE = 90,
  parameter int unsigned HALF_MARK  = 91,
  parameter int unsigned HALF_WIDE  = 92
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              wide_dev_i,
  output logic              tx_busy_o,
  output logic              tone_o,
  output logic              tone_en_o
);

  localparam int unsigned HALF_MAX = max3(HALF_SPACE, HALF_MARK, HALF_WIDE);
  localparam int unsigned HALF_W   = $clog2(HALF_MAX + 1);

  logic busy, cur_bit, tone_raw;

  fsk_bit_shifter #(
    .DATA_W  (DATA_W),
    .BIT_CLKS(BIT_CLKS)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .valid_i(valid_i),
    .ready_o(ready_o),
    .busy_o (busy),
    .bit_o  (cur_bit)
  );

  fsk_tone_gen #(
    .HALF_W    (HALF_W),
    .HALF_SPACE(HALF_SPACE),
    .HALF_MARK (HALF_MARK),
    .HALF_WIDE (HALF_WIDE)
  ) u_tone (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(busy),
    .bit_i (cur_bit),
    .wide_i(wide_dev_i),
    .tone_o(tone_raw)
  );

  assign tx_busy_o = busy;
  assign tone_en_o = busy;
  assign tone_o    = tone_raw && busy;

endmodule

// File: rtl/fsk_modulator_chk.sv
module fsk_modulator_chk #(
  parameter int unsigned HALF_SPACE = 90,
  parameter int unsigned HALF_MARK  = 91,
  parameter int unsigned HALF_WIDE  = 92
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic tx_busy_o,
  input logic tone_o,
  input logic tone_en_o
);

  logic [31:0] run_q;
  logic        tone_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= '0;
      tone_prev_q <= 1'b0;
    end else begin
      tone_prev_q <= tone_o;
      if (!tone_en_o)                run_q <= '0;
      else if (tone_o != tone_prev_q) run_q <= 32'd1;
      else                           run_q <= run_q + 32'd1;
    end
  end

  // R8
  tone_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tone_en_o |-> !tone_o);

  // R7
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> tx_busy_o);

  // R6
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy_o) |-> $past(valid_i && ready_o));

  // R6
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

  // R5
  half_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tone_en_o && tone_o != tone_prev_q) |->
      (run_q == HALF_SPACE || run_q == HALF_MARK || run_q == HALF_WIDE));

endmodule

bind fsk_modulator fsk_modulator_chk #(
  .HALF_SPACE(HALF_SPACE),
  .HALF_MARK (HALF_MARK),
  .HALF_WIDE (HALF_WIDE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .ready_o  (ready_o),
  .tx_busy_o(tx_busy_o),
  .tone_o   (tone_o),
  .tone_en_o(tone_en_o)
);

// File: tb/fsk_modulator_test.sv
module fsk_modulator_test;

  localparam int BIT_CLKS = 40;
  localparam int HS = 3;
  localparam int HM = 4;
  localparam int HW = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = '0;
  logic       valid = 1'b0;
  logic       wide = 1'b0;
  logic       ready, busy, tone, tone_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int busy_cycles = 0;

  always #5 clk = !clk;

  fsk_modulator #(
    .DATA_W(8), .BIT_CLKS(BIT_CLKS),
    .HALF_SPACE(HS), .HALF_MARK(HM), .HALF_WIDE(HW)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid),
    .ready_o(ready), .wide_dev_i(wide), .tx_busy_o(busy),
    .tone_o(tone), .tone_en_o(tone_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: queue of pending bits plus phase bookkeeping
  bit m_q[$];
  int m_timer = 0, m_phase = 0, m_len = 0;
  bit m_tone = 0, m_run = 0;

  function automatic int half_of(bit b, bit w);
    return !b ? HS : (w ? HW : HM);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q.delete(); m_timer = 0; m_phase = 0; m_len = 0; m_tone = 0; m_run = 0;
    end else begin
      bit act, rdy;
      int len_now;
      act = (m_q.size() != 0);
      rdy = !act || (m_q.size() == 1 && m_timer == BIT_CLKS - 1);
      if (act) begin
        len_now = m_run ? m_len : half_of(m_q[0], wide);
        if (m_phase == len_now - 1) begin
          m_tone = !m_tone; m_phase = 0; m_len = half_of(m_q[0], wide);
        end else begin
          m_phase++; m_len = len_now;
        end
      end else begin
        m_tone = 0; m_phase = 0; m_len = half_of(0, wide);
      end
      m_run = act;
      if (act) begin
        if (m_timer == BIT_CLKS - 1) begin m_timer = 0; void'(m_q.pop_front()); end
        else m_timer++;
      end
      if (valid && rdy) begin
        for (int i = 0; i < 8; i++) m_q.push_back(data[i]);
        m_timer = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_busy, e_rdy;
      e_busy = (m_q.size() != 0);
      e_rdy  = !e_busy || (m_q.size() == 1 && m_timer == BIT_CLKS - 1);
      chk(ready == e_rdy, "R6 ready", int'(ready), int'(e_rdy));
      chk(busy == e_busy && tone_en == e_busy, "R7 busy/enable", int'(busy), int'(e_busy));
      chk(tone == (m_tone && e_busy), "R5 tone waveform", int'(tone), int'(m_tone && e_busy));
      if (!tone_en) chk(!tone, "R8 idle tone low", int'(tone), 0);
      if (busy) busy_cycles++;
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    valid = 1'b1; data = b;
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic first_half(input logic [7:0] b, input bit w, input int exp, input string tag);
    int n;
    @(negedge clk);
    wide = w;
    busy_cycles = 0;
    send(b);
    chk(!ready, "R6 ready low after accept", int'(ready), 0);
    n = 0;
    while (!tone && n < 100) begin n++; @(negedge clk); end
    chk(n == exp, tag, n, exp);
    wait_idle();
    chk(busy_cycles == 8 * BIT_CLKS, "R4 byte duration", busy_cycles, 8 * BIT_CLKS);
    chk(ready, "R6 ready after last bit", int'(ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R9 reset ready", int'(ready), 1);
    chk(busy == 1'b0 && tone_en == 1'b0, "R9 reset busy", int'(busy), 0);
    chk(tone == 1'b0, "R9 reset tone", int'(tone), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!tone && !tone_en, "R8 idle after reset", int'(tone), 0);

    first_half(8'h00, 1'b0, HS, "R1 space half period");
    first_half(8'hFF, 1'b0, HM, "R2 mark half period");
    first_half(8'hFF, 1'b1, HW, "R3 wide mark half period");
    first_half(8'h00, 1'b1, HS, "R3 space unaffected by wide");
    first_half(8'h01, 1'b0, HM, "R4 lsb goes first");
    first_half(8'hFE, 1'b1, HS, "R4 lsb goes first wide");

    // mid-bit tone changes (R5) under mixed patterns
    @(negedge clk); wide = 1'b0;
    send(8'h55); wait_idle();
    send(8'hA3); wait_idle();
    @(negedge clk); wide = 1'b1;
    send(8'h3C); wait_idle();

    // back-to-back bytes keep busy continuous (R7)
    busy_cycles = 0;
    send(8'h96);
    send(8'h69);
    wait_idle();
    chk(busy_cycles == 16 * BIT_CLKS, "R7 back-to-back no gap", busy_cycles, 16 * BIT_CLKS);

    repeat (20) @(negedge clk);
    chk(!tone && !tone_en && ready, "R8 idle at end", int'(tone), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule